// File: doc/BRIEF.md
# Serial Command Receiver with Chain Output

This block receives commands over a three-wire serial link: a bit clock, a data line and a commit strobe. It also has a serial output that can feed the data input of the next device in a chain. All three inputs are sampled with a faster system clock. Each input passes through a two-stage synchroniser, and edges are detected in the system clock domain. On every rising bit-clock edge the block shifts one data bit, most significant bit first, into a 24-bit frame register.

A rising edge on the commit strobe checks the frame and then acts on it. The upper byte of the frame is the command and the lower 16 bits are the payload. A command can:
- write the data register,
- write the control register,
- clear both registers and give a one-cycle reset pulse,
- queue a register for readback on the serial output during the next frame,
- do nothing.

In normal operation a frame is accepted only when exactly 24 rising bit-clock edges occurred since the previous commit. Bit 3 of the control register turns on chain mode. In chain mode the length check is skipped, and bits that overflow the frame register appear on the serial output 24 edges later.

Top module: `srl_cmd_rx`

## Requirements
- R1: SDIN is sampled on each rising SCLK edge and shifted in MSB first. At a LATCH rising edge the most recent 24 bits form the frame: bits 23..16 are the command byte and bits 15..0 are the payload.
- R2: Command byte 0x01 in an accepted frame loads the payload into the data register.
- R3: Command byte 0x55 in an accepted frame loads the payload into the control register. Control bit 3 is the chain-enable flag.
- R4: With chain mode off, a frame whose rising-edge count differs from 24 changes neither register and gives no reset pulse.
- R5: The edge count clears on every LATCH rising edge and saturates at 25. After a bad frame, a following frame with exactly 24 edges is accepted.
- R6: Command byte 0x56 with payload bit 0 set clears both registers and raises rst_pulse_o for exactly one clock cycle. With payload bit 0 clear it does nothing.
- R7: Command byte 0x00, and any command byte not listed in these requirements, leaves both registers unchanged.
- R8: Command byte 0x02 selects a register by payload bit 0 (0 = data, 1 = control). It loads {8'h00, value} into the frame register. During the next frame that word is presented on SDO MSB first. SDO is updated on falling SCLK edges, so each bit is valid at the following rising edge.
- R9: With control bit 3 set, any number of edges is accepted, and SDO repeats the SDIN stream delayed by 24 rising edges.
- R10: With chain mode off and no readback pending, SDO is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial bit clock |
| sdin_i | input | 1 | Serial data in |
| latch_i | input | 1 | Frame commit strobe, acts on its rising edge |
| sdo_o | output | 1 | Serial data out (chain or readback) |
| data_o | output | 16 | Data register |
| ctrl_o | output | 16 | Control register |
| rst_pulse_o | output | 1 | One-cycle pulse on a clearing reset command |

## Verification
The assertions check on every cycle that:
- the edge counter stays within its saturation limit and clears after each commit;
- SDO moves only on a falling bit-clock edge or a readback load;
- a rejected frame leaves both registers untouched;
- the reset pulse lasts one cycle and coincides with cleared registers.

Only the bench scenarios can show the end-to-end serial behaviour:
- the bit ordering;
- the exact-24 acceptance across a sweep of frame lengths;
- the readback word appearing bit by bit on SDO in the following frame;
- the 24-edge chain delay.

// File: rtl/srl_cmd_pkg.sv
package srl_cmd_pkg;
    localparam int FRAME_W   = 24;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 16;
    localparam int CNT_MAX   = FRAME_W + 1;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);
    localparam int CHAIN_BIT = 3;
    localparam int SYNC_N    = 2;

    typedef enum logic [ADDR_W-1:0] {
        OP_NOP   = 8'h00,
        OP_WDATA = 8'h01,
        OP_RDBK  = 8'h02,
        OP_WCTRL = 8'h55,
        OP_RESET = 8'h56
    } op_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] payload;
    } frame_t;

    function automatic logic frame_ok(input logic [CNT_W-1:0] cnt, input logic chain);
        return chain || (cnt == CNT_W'(FRAME_W));
    endfunction
endpackage

// File: rtl/srl_sync_edge.sv
module srl_sync_edge #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            logic              prev_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q <= '0;
                    prev_q  <= 1'b0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_i[g]};
                    prev_q  <= chain_q[STAGES-1];
                end
            end
            assign level_o[g] = chain_q[STAGES-1];
            assign rise_o[g]  = chain_q[STAGES-1] & ~prev_q;
            assign fall_o[g]  = ~chain_q[STAGES-1] & prev_q;
        end
    endgenerate
endmodule

// File: rtl/srl_shift_frame.sv
module srl_shift_frame
    import srl_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    input  logic               sdin,
    input  logic               latch_rise,
    input  logic               load_en,
    input  logic [FRAME_W-1:0] load_word,
    input  logic               out_en,
    output frame_t             frame_o,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               sdo_o
);
    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               sdo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
        end else if (load_en) begin
            shreg_q <= load_word;
        end else if (sclk_rise) begin
            shreg_q <= {shreg_q[FRAME_W-2:0], sdin};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (latch_rise) begin
            cnt_q <= '0;
        end else if (sclk_rise && cnt_q != CNT_W'(CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sdo_q <= 1'b0;
        end else if (load_en) begin
            sdo_q <= load_word[FRAME_W-1];
        end else if (sclk_fall) begin
            sdo_q <= shreg_q[FRAME_W-1];
        end
    end

    assign frame_o = frame_t'(shreg_q);
    assign cnt_o   = cnt_q;
    assign sdo_o   = sdo_q & out_en;

    p_cnt_sat_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(CNT_MAX));
    p_cnt_clear_r5: assert property (@(posedge clk) disable iff (rst)
        latch_rise |=> cnt_q == '0);
    p_shift_in_r1: assert property (@(posedge clk) disable iff (rst)
        (sclk_rise && !load_en) |=> shreg_q[0] == $past(sdin));
    p_sdo_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdo_q) |-> $past(sclk_fall || load_en));
endmodule

// File: rtl/srl_cmd_decode.sv
module srl_cmd_decode
    import srl_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               commit,
    input  frame_t             frame_i,
    input  logic [CNT_W-1:0]   cnt_i,
    output logic [DATA_W-1:0]  data_o,
    output logic [DATA_W-1:0]  ctrl_o,
    output logic               rst_pulse_o,
    output logic               load_en_o,
    output logic [FRAME_W-1:0] load_word_o,
    output logic               out_en_o
);
    logic [DATA_W-1:0] data_q, ctrl_q;
    logic              rb_q, pulse_q, ok;
    op_e               op;

    assign op          = op_e'(frame_i.addr);
    assign ok          = commit && frame_ok(cnt_i, ctrl_q[CHAIN_BIT]);
    assign load_en_o   = ok && (op == OP_RDBK);
    assign load_word_o = {ADDR_W'(0), frame_i.payload[0] ? ctrl_q : data_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            ctrl_q  <= '0;
            rb_q    <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (commit) begin
                rb_q <= load_en_o;
            end
            if (ok) begin
                case (op)
                    OP_WDATA: data_q <= frame_i.payload;
                    OP_WCTRL: ctrl_q <= frame_i.payload;
                    OP_RESET: begin
                        if (frame_i.payload[0]) begin
                            data_q  <= '0;
                            ctrl_q  <= '0;
                            pulse_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign data_o      = data_q;
    assign ctrl_o      = ctrl_q;
    assign rst_pulse_o = pulse_q;
    assign out_en_o    = ctrl_q[CHAIN_BIT] | rb_q;

    p_bad_frame_r4: assert property (@(posedge clk) disable iff (rst)
        (commit && !ctrl_q[CHAIN_BIT] && cnt_i != CNT_W'(FRAME_W))
        |=> $stable(data_q) && $stable(ctrl_q) && !pulse_q);
    p_wdata_r2: assert property (@(posedge clk) disable iff (rst)
        (ok && frame_i.addr == 8'h01) |=> data_q == $past(frame_i.payload));
    p_pulse_clear_r6: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> (data_q == '0 && ctrl_q == '0));
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);
endmodule

// File: rtl/srl_cmd_rx.sv
module srl_cmd_rx
    import srl_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              sdin_i,
    input  logic              latch_i,
    output logic              sdo_o,
    output logic [DATA_W-1:0] data_o,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              rst_pulse_o
);
    logic [2:0]         lvl, rise, fall;
    frame_t             frame;
    logic [CNT_W-1:0]   cnt;
    logic               load_en, out_en;
    logic [FRAME_W-1:0] load_word;

    srl_sync_edge #(.N(3), .STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({latch_i, sdin_i, sclk_i}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    srl_shift_frame u_shift (
        .clk        (clk),
        .rst        (rst),
        .sclk_rise  (rise[0]),
        .sclk_fall  (fall[0]),
        .sdin       (lvl[1]),
        .latch_rise (rise[2]),
        .load_en    (load_en),
        .load_word  (load_word),
        .out_en     (out_en),
        .frame_o    (frame),
        .cnt_o      (cnt),
        .sdo_o      (sdo_o)
    );

    srl_cmd_decode u_dec (
        .clk         (clk),
        .rst         (rst),
        .commit      (rise[2]),
        .frame_i     (frame),
        .cnt_i       (cnt),
        .data_o      (data_o),
        .ctrl_o      (ctrl_o),
        .rst_pulse_o (rst_pulse_o),
        .load_en_o   (load_en),
        .load_word_o (load_word),
        .out_en_o    (out_en)
    );

    p_sdo_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_o[CHAIN_BIT] == 1'b0 && $past(rise[2]) && !$past(load_en)) |-> !sdo_o);
endmodule

// File: tb/tb_srl_cmd_rx.sv
module tb_srl_cmd_rx;
    localparam int H = 6;

    logic clk = 1'b0, rst = 1'b1;
    logic sclk = 1'b0, sdin = 1'b0, latch = 1'b0;
    logic sdo, pulse;
    logic [15:0] data, ctrl;
    int checks = 0, errors = 0, pulses = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    srl_cmd_rx dut (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sdin_i(sdin), .latch_i(latch),
        .sdo_o(sdo), .data_o(data), .ctrl_o(ctrl), .rst_pulse_o(pulse)
    );

    always @(posedge clk) if (!rst && pulse) pulses <= pulses + 1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [63:0] bits, input int n, output logic [63:0] seen);
        seen = '0;
        for (int k = 0; k < n; k++) begin
            sdin = bits[n-1-k];
            tick(H);
            seen[n-1-k] = sdo;
            sclk = 1'b1;
            tick(H);
            sclk = 1'b0;
        end
        tick(H);
    endtask

    task automatic commit();
        latch = 1'b1;
        tick(8);
        latch = 1'b0;
        tick(8);
    endtask

    task automatic frame(input logic [7:0] op, input logic [15:0] pl, output logic [63:0] seen);
        shift_bits({40'b0, op, pl}, 24, seen);
        commit();
    endtask

    initial begin
        logic [63:0] s;
        logic [15:0] v;
        int p0;
        tick(5);
        rst = 1'b0;
        tick(5);
        chk("reset data", data, 0);
        chk("reset ctrl", ctrl, 0);
        chk("reset sdo R10", sdo, 0);
        chk("reset pulse", pulses, 0);

        // R1 R2: sweep of data words, each bit position exercised
        for (int i = 0; i < 16; i++) begin
            v = 16'((i * 16'h1111) ^ (16'h8001 << (i % 8)) ^ (1 << i));
            frame(8'h01, v, s);
            chk("R1 R2 data write", data, v);
        end

        // R3: control write with chain bit clear
        frame(8'h55, 16'hA5F0, s);
        chk("R3 ctrl write", ctrl, 16'hA5F0);
        frame(8'h01, 16'h1357, s);

        // R4: frame lengths other than 24 are rejected
        for (int n = 20; n <= 28; n++) begin
            if (n == 24) continue;
            shift_bits({40'b0, 8'h01, 16'hDEAD} | (64'h3 << 24), n, s);
            commit();
            chk("R4 bad length data", data, 16'h1357);
            chk("R4 bad length ctrl", ctrl, 16'hA5F0);
        end
        p0 = pulses;
        shift_bits({40'b0, 8'h56, 16'h0001}, 23, s);
        commit();
        chk("R4 bad reset pulse", pulses, p0);

        // R5: counter clears; 24-edge frame after an over-long one commits
        shift_bits(64'hFFFF_FFFF, 30, s);
        commit();
        frame(8'h01, 16'h2468, s);
        chk("R5 recover after bad frame", data, 16'h2468);

        // R7: NOP and unlisted commands
        frame(8'h00, 16'hFFFF, s);
        chk("R7 nop data", data, 16'h2468);
        frame(8'h33, 16'h0000, s);
        chk("R7 unknown data", data, 16'h2468);
        chk("R7 unknown ctrl", ctrl, 16'hA5F0);

        // R6: reset command
        p0 = pulses;
        frame(8'h56, 16'hFFFE, s);
        chk("R6 reset bit0 clear data", data, 16'h2468);
        chk("R6 reset bit0 clear pulse", pulses, p0);
        frame(8'h56, 16'h0001, s);
        chk("R6 reset data", data, 0);
        chk("R6 reset ctrl", ctrl, 0);
        chk("R6 one pulse", pulses, p0 + 1);

        // R8: readback of data then control
        frame(8'h01, 16'h5A3C, s);
        frame(8'h55, 16'h00C1, s);
        frame(8'h02, 16'h0000, s);
        frame(8'h00, 16'h0000, s);
        chk("R8 readback data", s[23:0], {8'h00, 16'h5A3C});
        frame(8'h02, 16'h0001, s);
        frame(8'h00, 16'h0000, s);
        chk("R8 readback ctrl", s[23:0], {8'h00, 16'h00C1});

        // R10: quiet SDO after readback consumed
        frame(8'h00, 16'hFFFF, s);
        chk("R10 sdo low", s[23:0], 0);

        // R9: chain mode
        frame(8'h55, 16'h0008, s);
        shift_bits({16'b0, 8'h01, 16'h1234, 8'h01, 16'h9876}, 48, s);
        commit();
        chk("R9 chain delay", s[23:0], {8'h01, 16'h1234});
        chk("R9 chain commit", data, 16'h9876);
        shift_bits({34'b0, 6'h15, 8'h01, 16'hBEEF}, 30, s);
        commit();
        chk("R9 any length", data, 16'hBEEF);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule